// File: doc/BRIEF.md
# Two's Complement Adder-Subtractor

This block performs one of four arithmetic operations on two operands of a configurable width: addition, subtraction, increment by one and decrement by one. All four use a single ripple chain of full-adder cells. A small conditioning stage in front of the chain picks the second operand and the carry-in from the operation code. Subtraction feeds the bitwise inverse of B and a carry-in of one. Increment feeds zero and a carry-in of one. Decrement feeds all ones and a carry-in of zero.

The arithmetic core is purely combinational. The top module places one output register stage after the core so that results, carry and overflow can be checked against a clock. The carry-out passes through unchanged: in subtraction it reads 1 when no borrow occurred. Signed overflow is the exclusive-or of the carries into and out of the most significant cell.

Top module: `addsub_unit`

## Requirements
- R1: While rst_n is low at a rising clock edge, the outputs after that edge are res = 0, carry_out = 0 and ovf = 0.
- R2: With op_sel = 2'b00 (add), the output after the next rising edge has {carry_out, res} equal to the (W+1)-bit unsigned sum of op_a and op_b.
- R3: With op_sel = 2'b01 (subtract), the output after the next edge has res = op_a - op_b modulo 2^W, and carry_out = 1 exactly when op_a >= op_b taken as unsigned values (no borrow).
- R4: With op_sel = 2'b10 (increment), res = op_a + 1 modulo 2^W and carry_out = 1 exactly when op_a is all ones. op_b has no effect on any output.
- R5: With op_sel = 2'b11 (decrement), res = op_a - 1 modulo 2^W and carry_out = 1 exactly when op_a is non-zero. op_b has no effect on any output.
- R6: ovf is 1 exactly when the selected operation, evaluated on op_a and op_b as signed two's complement numbers, gives a value outside the signed W-bit range.
- R7: Outputs change only at a rising clock edge and show the inputs sampled at that edge, a latency of one cycle. A change of the inputs between edges leaves the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| op_a | input | W | First operand |
| op_b | input | W | Second operand, unused for increment and decrement |
| op_sel | input | 2 | Operation: 00 add, 01 subtract, 10 increment, 11 decrement |
| res | output | W | Registered result |
| carry_out | output | 1 | Registered carry out of the most significant cell |
| ovf | output | 1 | Registered signed overflow flag |

## Verification
A fault in the conditioning stage, such as a missing inversion of B or a wrong carry-in, shows up at the ports one cycle after the affected operation is applied. It appears as a result that is off by one or off by a complement, and the carry and overflow flags are usually wrong as well. A broken link in the carry chain corrupts res in every bit above the fault as soon as a carry has to pass through that link. The vectors therefore include carries that run the full width, sign-boundary operands and wrap-around at zero and at all ones. A wrong choice of carry for the overflow flag only shows on operands that cross the signed boundary, and those are included.

// File: rtl/addsub_pkg.sv
// Package: shared operation encoding for the adder-subtractor.
// Assumes: a two-bit operation select on the top-level port.
package addsub_pkg;
    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_SUB = 2'b01,
        OP_INC = 2'b10,
        OP_DEC = 2'b11
    } op_e;
endpackage

// File: rtl/addsub_fa_cell.sv
// Module: single full-adder cell, one stage of the ripple chain.
// Assumes: nothing beyond one-bit inputs; purely combinational.
module addsub_fa_cell (
    input  logic x_in,
    input  logic y_in,
    input  logic c_in,
    output logic s_out,
    output logic c_out
);
    logic half_p;

    // Propagate term, sum and carry of one bit position.
    always_comb begin
        half_p = x_in ^ y_in;
        s_out  = half_p ^ c_in;
        c_out  = (x_in & y_in) | (c_in & half_p);
    end
endmodule

// File: rtl/addsub_opnd_cond.sv
// Module: conditions the second operand and carry-in from the operation code
//         so that one adder chain serves all four operations.
// Assumes: W >= 1; the op code follows addsub_pkg::op_e.
module addsub_opnd_cond
    import addsub_pkg::*;
#(
    parameter int W = 16
) (
    input  op_e          op,
    input  logic [W-1:0] b_raw,
    output logic [W-1:0] b_eff,
    output logic         c_first
);
    logic [W-1:0] inv_mask;
    logic [W-1:0] b_pass;

    // Per-bit inversion through XOR, driven by the subtract select.
    always_comb begin
        inv_mask = {W{op == OP_SUB}};
    end

    genvar g;
    generate
        for (g = 0; g < W; g++) begin : g_inv
            assign b_pass[g] = b_raw[g] ^ inv_mask[g];
        end
    endgenerate

    // Pick the chain's B input and carry-in for the operation in use.
    always_comb begin
        unique case (op)
            OP_ADD: begin b_eff = b_pass;     c_first = 1'b0; end
            OP_SUB: begin b_eff = b_pass;     c_first = 1'b1; end
            OP_INC: begin b_eff = '0;         c_first = 1'b1; end
            OP_DEC: begin b_eff = {W{1'b1}};  c_first = 1'b0; end
            default: begin b_eff = b_pass;    c_first = 1'b0; end
        endcase
    end
endmodule

// File: rtl/addsub_ripple.sv
// Module: W-stage ripple chain of full-adder cells.
// Assumes: W >= 1; carry moves from bit i to bit i+1, delay linear in W.
module addsub_ripple #(
    parameter int W = 16
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         c0,
    output logic [W-1:0] sum,
    output logic         c_top_in,
    output logic         c_top_out
);
    logic [W:0] chain;

    // Seed the chain with the conditioned carry-in.
    always_comb begin
        chain[0] = c0;
    end

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_cell
            addsub_fa_cell u_cell (
                .x_in  (x[i]),
                .y_in  (y[i]),
                .c_in  (chain[i]),
                .s_out (sum[i]),
                .c_out (chain[i+1])
            );
        end
    endgenerate

    // Expose carries around the most significant cell.
    always_comb begin
        c_top_in  = chain[W-1];
        c_top_out = chain[W];
    end
endmodule

// File: rtl/addsub_unit.sv
// Module: top level; combinational add/sub/inc/dec core followed by one
//         output register stage used for timing checks.
// Assumes: synchronous active-low reset; op_sel encoded as addsub_pkg::op_e.
module addsub_unit
    import addsub_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic [1:0]   op_sel,
    output logic [W-1:0] res,
    output logic         carry_out,
    output logic         ovf
);
    op_e          op_cur;
    logic [W-1:0] b_cond;
    logic         cin_cond;
    logic [W-1:0] sum_w;
    logic         c_msb_in;
    logic         c_msb_out;
    logic         ovf_w;

    // Interpret the raw select as an operation code.
    always_comb begin
        op_cur = op_e'(op_sel);
    end

    addsub_opnd_cond #(.W(W)) u_cond (
        .op      (op_cur),
        .b_raw   (op_b),
        .b_eff   (b_cond),
        .c_first (cin_cond)
    );

    addsub_ripple #(.W(W)) u_chain (
        .x         (op_a),
        .y         (b_cond),
        .c0        (cin_cond),
        .sum       (sum_w),
        .c_top_in  (c_msb_in),
        .c_top_out (c_msb_out)
    );

    // Signed overflow from the carries around the top cell.
    always_comb begin
        ovf_w = c_msb_in ^ c_msb_out;
    end

    // Output register stage with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res       <= '0;
            carry_out <= 1'b0;
            ovf       <= 1'b0;
        end else begin
            res       <= sum_w;
            carry_out <= c_msb_out;
            ovf       <= ovf_w;
        end
    end
endmodule

// File: rtl/addsub_chk.sv
// Module: property checker for addsub_unit, attached by bind below.
// Assumes: same W as the unit; reference values are computed behaviourally.
module addsub_chk
    import addsub_pkg::*;
#(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] op_a,
    input logic [W-1:0] op_b,
    input logic [1:0]   op_sel,
    input logic [W-1:0] res,
    input logic         carry_out,
    input logic         ovf
);
    localparam logic [W-1:0] ONE  = W'(1);
    localparam logic [W-1:0] ALL1 = {W{1'b1}};

    logic signed [W:0] sx_a;
    logic signed [W:0] sx_b;
    logic signed [W:0] s_full;
    logic              exp_ovf;

    // Behavioural signed result and its range check.
    always_comb begin
        sx_a = {op_a[W-1], op_a};
        sx_b = {op_b[W-1], op_b};
        unique case (op_e'(op_sel))
            OP_ADD:  s_full = sx_a + sx_b;
            OP_SUB:  s_full = sx_a - sx_b;
            OP_INC:  s_full = sx_a + (W+1)'(1);
            default: s_full = sx_a - (W+1)'(1);
        endcase
        exp_ovf = s_full[W] != s_full[W-1];
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (res == '0 && !carry_out && !ovf)); // R1

    AST_ADD_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_ADD) |=>
        ({carry_out, res} == ({1'b0, $past(op_a)} + {1'b0, $past(op_b)}))); // R2

    AST_SUB_DIFF: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_SUB) |=>
        (res == $past(op_a) - $past(op_b) && carry_out == ($past(op_a) >= $past(op_b)))); // R3

    AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_INC) |=>
        (res == $past(op_a) + ONE && carry_out == ($past(op_a) == ALL1))); // R4

    AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_DEC) |=>
        (res == $past(op_a) - ONE && carry_out == ($past(op_a) != '0))); // R5

    AST_SIGNED_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (ovf == $past(exp_ovf))); // R6
endmodule

bind addsub_unit addsub_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_a      (op_a),
    .op_b      (op_b),
    .op_sel    (op_sel),
    .res       (res),
    .carry_out (carry_out),
    .ovf       (ovf)
);

// File: tb/sim_addsub_unit.sv
module sim_addsub_unit;
    localparam int W = 16;

    typedef struct packed {
        logic [1:0]   op;
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic [W-1:0] r;
        logic         c;
        logic         v;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{2'b00, 16'h0001, 16'h0002, 16'h0003, 1'b0, 1'b0}, // R2
        '{2'b00, 16'hFFFF, 16'h0001, 16'h0000, 1'b1, 1'b0}, // R2 full carry
        '{2'b00, 16'h7FFF, 16'h0001, 16'h8000, 1'b0, 1'b1}, // R6
        '{2'b00, 16'h8000, 16'h8000, 16'h0000, 1'b1, 1'b1}, // R6
        '{2'b00, 16'h1234, 16'h4321, 16'h5555, 1'b0, 1'b0}, // R2
        '{2'b01, 16'h0005, 16'h0003, 16'h0002, 1'b1, 1'b0}, // R3
        '{2'b01, 16'h0003, 16'h0005, 16'hFFFE, 1'b0, 1'b0}, // R3 borrow
        '{2'b01, 16'h8000, 16'h0001, 16'h7FFF, 1'b1, 1'b1}, // R6
        '{2'b01, 16'h7FFF, 16'hFFFF, 16'h8000, 1'b0, 1'b1}, // R6
        '{2'b01, 16'h1234, 16'h1234, 16'h0000, 1'b1, 1'b0}, // R3 equal
        '{2'b10, 16'h7FFF, 16'hABCD, 16'h8000, 1'b0, 1'b1}, // R4
        '{2'b10, 16'hFFFF, 16'h1111, 16'h0000, 1'b1, 1'b0}, // R4 wrap
        '{2'b10, 16'h00FF, 16'h0000, 16'h0100, 1'b0, 1'b0}, // R4
        '{2'b11, 16'h0000, 16'h5555, 16'hFFFF, 1'b0, 1'b0}, // R5 wrap
        '{2'b11, 16'h8000, 16'h0000, 16'h7FFF, 1'b1, 1'b1}, // R5
        '{2'b11, 16'h0001, 16'hFFFF, 16'h0000, 1'b1, 1'b0}  // R5
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic [1:0]   op_sel = 2'b00;
    logic [W-1:0] res;
    logic         carry_out;
    logic         ovf;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always #2 clk = ~clk;

    addsub_unit #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
        .res(res), .carry_out(carry_out), .ovf(ovf)
    );

    task automatic check(input string tag, input logic [W-1:0] er,
                         input logic ec, input logic ev);
        n_chk++;
        if (res !== er || carry_out !== ec || ovf !== ev) begin
            n_err++;
            $display("FAIL %s: got res=%h c=%b v=%b, expected res=%h c=%b v=%b",
                     tag, res, carry_out, ovf, er, ec, ev);
        end
    endtask

    task automatic apply(input logic [1:0] o, input logic [W-1:0] a,
                         input logic [W-1:0] b);
        @(negedge clk);
        op_sel = o; op_a = a; op_b = b;
        @(negedge clk);
    endtask

    initial begin
        // R1: reset with non-zero inputs present
        op_a = 16'hFFFF; op_b = 16'h0001; op_sel = 2'b00;
        repeat (3) @(negedge clk);
        check("R1 reset clear", '0, 1'b0, 1'b0);
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) begin
            apply(VECS[k].op, VECS[k].a, VECS[k].b);
            check($sformatf("vec%0d op=%0d (R2/R3/R4/R5/R6)", k, VECS[k].op),
                  VECS[k].r, VECS[k].c, VECS[k].v);
        end

        // R4: op_b ignored during increment
        apply(2'b10, 16'h0010, 16'hFFFF);
        check("R4 b ignored", 16'h0011, 1'b0, 1'b0);
        // R5: op_b ignored during decrement
        apply(2'b11, 16'h0010, 16'h7FFF);
        check("R5 b ignored", 16'h000F, 1'b1, 1'b0);

        // R7: inputs change between edges, outputs hold until next edge
        apply(2'b00, 16'h0100, 16'h0200);
        op_a = 16'h7FFF; op_b = 16'h7FFF;
        #1;
        check("R7 hold between edges", 16'h0300, 1'b0, 1'b0);
        @(negedge clk);
        check("R7 one-cycle update", 16'hFFFE, 1'b0, 1'b1);

        // R1: reset in mid-run clears outputs
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid-run reset", '0, 1'b0, 1'b0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: run did not complete");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule